// File: doc/BRIEF.md
# Dispatch-time ready-cycle scheduler

This block gives every instruction of a decode group a wait delay exactly once, when the group is dispatched. The instruction then never polls for operand readiness. A group holds up to `LANES` instructions, and lane 0 is the oldest. Each instruction carries two source register indices, one destination index and an operation latency. A table with one entry per architectural register holds the cycle in which that register's value is predicted to be available.

The work is split over two pipeline stages.

- **First stage (lookup):** the table is read for both sources of every lane. A value that the group now in the second stage is about to write overrides the table read.
- **Second stage (resolve):** a source produced by an older lane of the same group takes that lane's freshly computed ready time instead of the table value. The start time is the later of the two sources. The destination's ready time is the start time plus the latency, and it is written back to the table.

The output delay is the start time counted from the cycle in which the result leaves the block, capped at a maximum wait. A reschedule flag is raised when the cap had to be applied.

Table entries keep absolute cycle stamps on a free-running counter of `TIME_W` bits. Each entry also has a live bit that clears itself once its stamp has passed, so an old entry never aliases after the counter wraps. Stored ready times saturate at half the counter range. Reset and `flush` mark every register as ready now, and `flush` also drops the group held in the second stage.

Top module: `tt_presched`

## Requirements
- R1: After reset `out_valid` is all zero, and every register reads as ready now: a group whose sources have no producer gets delay 0 on every valid lane.
- R2: A group presented in cycle T appears in cycle T+1, with `out_valid` equal to the `in_valid` of cycle T; in cycle T itself `out_valid` still reflects the previous cycle.
- R3: Take a producer that leaves the block in cycle C with delay d (start below the cap) and latency L. A consumer of its destination leaving in cycle C' gets start max(0, C+d+L-C'). When both sources have producers, the later one wins.
- R4: Within a group, a source that matches the destination of an older valid lane (lower lane index) uses that lane's start plus latency, and never the table value.
- R5: A group presented in the cycle right after its producer's group sees the producer's ready time, even though the table write has not yet happened.
- R6: When several valid lanes of one group write the same destination, the youngest one (highest index) is seen by later lanes of that group and by later groups.
- R7: The output delay equals min(start, DMAX). `out_resched` of a valid lane is 1 exactly when start > DMAX, and then the delay equals DMAX.
- R8: In the cycle after `flush` is high, `out_valid` is zero. The group that was in the second stage does not write the table, and every register reads as ready now afterwards.
- R9: An entry whose ready cycle has passed reads as ready now, including after more cycles than the counter range (256 with `TIME_W`=8).
- R10: A lane with `in_valid` low writes nothing to the table and is never used as a same-group producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears the table and drops the group in the second stage |
| in_valid | input | LANES | Lane holds an instruction |
| in_src_a | input | LANES x REG_W | First source register per lane |
| in_src_b | input | LANES x REG_W | Second source register per lane |
| in_dst | input | LANES x REG_W | Destination register per lane |
| in_lat | input | LANES x LAT_W | Operation latency in cycles per lane |
| out_valid | output | LANES | Lane result valid (one cycle after input) |
| out_delay | output | LANES x DLY_W | Cycles to wait before starting, capped at DMAX |
| out_resched | output | LANES | Start lay beyond DMAX; the delay was capped |

## Verification
The pipeline properties take for granted two things about the inputs: `in_valid` and `flush` are low while reset is applied, and `flush` only changes between clock edges. The dependence property also relies on stored ready times staying within the saturation horizon, which the latency width guarantees. The bench drives every input on the falling edge and holds it low during reset. It applies `flush` only together with groups it expects to be dropped. It keeps dependence chains short enough that the horizon is never the limiting value, except where the cap on the delay is the thing under test.

// File: rtl/tt_presched_pkg.sv
`timescale 1ns/1ps
package tt_presched_pkg;
   localparam int unsigned TT_LANES_DEF = 4;
   localparam int unsigned TT_NREGS_DEF = 32;
   localparam int unsigned TT_TIME_W_DEF = 8;
   localparam int unsigned TT_LAT_W_DEF = 4;
   localparam int unsigned TT_DMAX_DEF = 15;

   // largest relative time a table entry may hold for a counter width
   function automatic int unsigned tt_horizon(int unsigned time_w);
      return (1 << (time_w - 1)) - 1;
   endfunction
endpackage

// File: rtl/tt_table.sv
`timescale 1ns/1ps
module tt_table
   import tt_presched_pkg::*;
#(
   parameter int unsigned NREGS = TT_NREGS_DEF,
   parameter int unsigned REG_W = 5,
   parameter int unsigned TIME_W = TT_TIME_W_DEF,
   parameter int unsigned LANES = TT_LANES_DEF,
   parameter int unsigned RPORTS = 2 * TT_LANES_DEF
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic [RPORTS-1:0][REG_W-1:0]       rd_idx,
   output logic [RPORTS-1:0][TIME_W-1:0]      rd_rel,
   input  logic [LANES-1:0]                   wr_en,
   input  logic [LANES-1:0][REG_W-1:0]        wr_idx,
   input  logic [LANES-1:0][TIME_W-1:0]       wr_rel
);
   localparam logic [TIME_W-1:0] HZN = TIME_W'(tt_horizon(TIME_W));
   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   logic [TIME_W-1:0]              now_q;
   logic [NREGS-1:0]               live_q;
   logic [NREGS-1:0][TIME_W-1:0]   stamp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + ONE;
   end

   for (genvar e = 0; e < NREGS; e++) begin : g_ent
      logic              hit;
      logic [TIME_W-1:0] hit_rel;

      // the youngest writing lane overrides older ones
      always_comb begin
         hit = 1'b0;
         hit_rel = '0;
         for (int j = 0; j < LANES; j++) begin
            if (wr_en[j] && wr_idx[j] == REG_W'(e)) begin
               hit = 1'b1;
               hit_rel = wr_rel[j];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[e]  <= 1'b0;
            stamp_q[e] <= '0;
         end else if (flush) begin
            live_q[e]  <= 1'b0;
         end else if (hit) begin
            live_q[e]  <= hit_rel > ONE;
            stamp_q[e] <= now_q + hit_rel;
         end else if (live_q[e] && stamp_q[e] == now_q + ONE) begin
            live_q[e]  <= 1'b0;
         end
      end

      // R9
      live_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live_q[e] |-> ((stamp_q[e] - now_q) != '0 && (stamp_q[e] - now_q) <= HZN));
   end

   always_comb begin
      for (int p = 0; p < RPORTS; p++) begin
         rd_rel[p] = live_q[rd_idx[p]] ? (stamp_q[rd_idx[p]] - now_q) : '0;
      end
   end
endmodule

// File: rtl/tt_lookup_stage.sv
`timescale 1ns/1ps
module tt_lookup_stage
   import tt_presched_pkg::*;
#(
   parameter int unsigned LANES = TT_LANES_DEF,
   parameter int unsigned REG_W = 5,
   parameter int unsigned TIME_W = TT_TIME_W_DEF,
   parameter int unsigned LAT_W = TT_LAT_W_DEF
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic [LANES-1:0]                   in_valid,
   input  logic [LANES-1:0][REG_W-1:0]        in_src_a,
   input  logic [LANES-1:0][REG_W-1:0]        in_src_b,
   input  logic [LANES-1:0][REG_W-1:0]        in_dst,
   input  logic [LANES-1:0][LAT_W-1:0]        in_lat,
   input  logic [LANES-1:0][TIME_W-1:0]       tbl_a,
   input  logic [LANES-1:0][TIME_W-1:0]       tbl_b,
   input  logic [LANES-1:0]                   pend_en,
   input  logic [LANES-1:0][REG_W-1:0]        pend_dst,
   input  logic [LANES-1:0][TIME_W-1:0]       pend_rel,
   output logic [LANES-1:0]                   s_valid,
   output logic [LANES-1:0][REG_W-1:0]        s_src_a,
   output logic [LANES-1:0][REG_W-1:0]        s_src_b,
   output logic [LANES-1:0][REG_W-1:0]        s_dst,
   output logic [LANES-1:0][LAT_W-1:0]        s_lat,
   output logic [LANES-1:0][TIME_W-1:0]       s_rel_a,
   output logic [LANES-1:0][TIME_W-1:0]       s_rel_b
);
   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   logic [LANES-1:0][TIME_W-1:0] nxt_a, nxt_b;

   // in-flight group bypass, then rebase to the next cycle
   always_comb begin : bypass_p
      logic [TIME_W-1:0] ra, rb;
      for (int i = 0; i < LANES; i++) begin
         ra = tbl_a[i];
         rb = tbl_b[i];
         for (int j = 0; j < LANES; j++) begin
            if (pend_en[j] && pend_dst[j] == in_src_a[i]) ra = pend_rel[j];
            if (pend_en[j] && pend_dst[j] == in_src_b[i]) rb = pend_rel[j];
         end
         nxt_a[i] = (ra == '0) ? '0 : ra - ONE;
         nxt_b[i] = (rb == '0) ? '0 : rb - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= '0;
         s_src_a <= '0;
         s_src_b <= '0;
         s_dst   <= '0;
         s_lat   <= '0;
         s_rel_a <= '0;
         s_rel_b <= '0;
      end else begin
         s_valid <= flush ? '0 : in_valid;
         s_src_a <= in_src_a;
         s_src_b <= in_src_b;
         s_dst   <= in_dst;
         s_lat   <= in_lat;
         s_rel_a <= nxt_a;
         s_rel_b <= nxt_b;
      end
   end
endmodule

// File: rtl/tt_resolve_stage.sv
`timescale 1ns/1ps
module tt_resolve_stage
   import tt_presched_pkg::*;
#(
   parameter int unsigned LANES = TT_LANES_DEF,
   parameter int unsigned REG_W = 5,
   parameter int unsigned TIME_W = TT_TIME_W_DEF,
   parameter int unsigned LAT_W = TT_LAT_W_DEF,
   parameter int unsigned DMAX = TT_DMAX_DEF,
   parameter int unsigned DLY_W = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [LANES-1:0]                   s_valid,
   input  logic [LANES-1:0][REG_W-1:0]        s_src_a,
   input  logic [LANES-1:0][REG_W-1:0]        s_src_b,
   input  logic [LANES-1:0][REG_W-1:0]        s_dst,
   input  logic [LANES-1:0][LAT_W-1:0]        s_lat,
   input  logic [LANES-1:0][TIME_W-1:0]       s_rel_a,
   input  logic [LANES-1:0][TIME_W-1:0]       s_rel_b,
   output logic [LANES-1:0][DLY_W-1:0]        out_delay,
   output logic [LANES-1:0]                   out_resched,
   output logic [LANES-1:0][TIME_W-1:0]       wr_rel
);
   localparam logic [TIME_W-1:0] HZN  = TIME_W'(tt_horizon(TIME_W));
   localparam logic [TIME_W-1:0] DCAP = TIME_W'(DMAX);

   logic [LANES-1:0][TIME_W-1:0] start, rdy;

   always_comb begin : resolve_p
      logic [TIME_W-1:0] oa, ob;
      logic [TIME_W:0]   sum;
      start = '0;
      rdy = '0;
      out_delay = '0;
      out_resched = '0;
      for (int i = 0; i < LANES; i++) begin
         oa = s_rel_a[i];
         ob = s_rel_b[i];
         // older lanes in ascending order: the youngest match wins
         for (int j = 0; j < LANES; j++) begin
            if (j < i && s_valid[j]) begin
               if (s_dst[j] == s_src_a[i]) oa = rdy[j];
               if (s_dst[j] == s_src_b[i]) ob = rdy[j];
            end
         end
         start[i] = (oa > ob) ? oa : ob;
         sum = {1'b0, start[i]} + (TIME_W+1)'(s_lat[i]);
         rdy[i] = (sum > {1'b0, HZN}) ? HZN : sum[TIME_W-1:0];
         if (s_valid[i]) begin
            out_resched[i] = start[i] > DCAP;
            out_delay[i] = (start[i] > DCAP) ? DLY_W'(DMAX) : start[i][DLY_W-1:0];
         end
      end
      wr_rel = rdy;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      // R7
      cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_resched[i] |-> out_delay[i] == DLY_W'(DMAX));
      if (i > 0) begin : g_dep
         // R4
         prod_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_valid[i] && s_valid[i-1] && s_src_a[i] == s_dst[i-1])
               |-> start[i] >= rdy[i-1]);
      end
   end
endmodule

// File: rtl/tt_presched.sv
`timescale 1ns/1ps
module tt_presched
   import tt_presched_pkg::*;
#(
   parameter int unsigned LANES = TT_LANES_DEF,
   parameter int unsigned NREGS = TT_NREGS_DEF,
   parameter int unsigned TIME_W = TT_TIME_W_DEF,
   parameter int unsigned LAT_W = TT_LAT_W_DEF,
   parameter int unsigned DMAX = TT_DMAX_DEF,
   localparam int unsigned REG_W = $clog2(NREGS),
   localparam int unsigned DLY_W = $clog2(DMAX + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic [LANES-1:0]                   in_valid,
   input  logic [LANES-1:0][REG_W-1:0]        in_src_a,
   input  logic [LANES-1:0][REG_W-1:0]        in_src_b,
   input  logic [LANES-1:0][REG_W-1:0]        in_dst,
   input  logic [LANES-1:0][LAT_W-1:0]        in_lat,
   output logic [LANES-1:0]                   out_valid,
   output logic [LANES-1:0][DLY_W-1:0]        out_delay,
   output logic [LANES-1:0]                   out_resched
);
   localparam int unsigned RPORTS = 2 * LANES;

   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (NREGS == (1 << REG_W)) else $error("NREGS must be a power of two");
      assert (DMAX >= 1 && DMAX < tt_horizon(TIME_W)) else $error("DMAX outside horizon");
      assert (LAT_W < TIME_W) else $error("LAT_W must be below TIME_W");
   end

   logic [RPORTS-1:0][REG_W-1:0]   rd_idx;
   logic [RPORTS-1:0][TIME_W-1:0]  rd_rel;
   logic [LANES-1:0][TIME_W-1:0]   tbl_a, tbl_b;
   logic [LANES-1:0]               s_valid;
   logic [LANES-1:0][REG_W-1:0]    s_src_a, s_src_b, s_dst;
   logic [LANES-1:0][LAT_W-1:0]    s_lat;
   logic [LANES-1:0][TIME_W-1:0]   s_rel_a, s_rel_b, wr_rel;
   logic [LANES-1:0]               wr_en;

   for (genvar i = 0; i < LANES; i++) begin : g_port
      assign rd_idx[i]         = in_src_a[i];
      assign rd_idx[LANES + i] = in_src_b[i];
      assign tbl_a[i]          = rd_rel[i];
      assign tbl_b[i]          = rd_rel[LANES + i];
   end

   assign wr_en = flush ? '0 : s_valid;
   assign out_valid = s_valid;

   tt_table #(
      .NREGS(NREGS), .REG_W(REG_W), .TIME_W(TIME_W), .LANES(LANES), .RPORTS(RPORTS)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .rd_idx(rd_idx), .rd_rel(rd_rel),
      .wr_en(wr_en), .wr_idx(s_dst), .wr_rel(wr_rel)
   );

   tt_lookup_stage #(
      .LANES(LANES), .REG_W(REG_W), .TIME_W(TIME_W), .LAT_W(LAT_W)
   ) u_lookup (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_dst(in_dst), .in_lat(in_lat),
      .tbl_a(tbl_a), .tbl_b(tbl_b),
      .pend_en(wr_en), .pend_dst(s_dst), .pend_rel(wr_rel),
      .s_valid(s_valid), .s_src_a(s_src_a), .s_src_b(s_src_b),
      .s_dst(s_dst), .s_lat(s_lat), .s_rel_a(s_rel_a), .s_rel_b(s_rel_b)
   );

   tt_resolve_stage #(
      .LANES(LANES), .REG_W(REG_W), .TIME_W(TIME_W), .LAT_W(LAT_W),
      .DMAX(DMAX), .DLY_W(DLY_W)
   ) u_resolve (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_src_a(s_src_a), .s_src_b(s_src_b),
      .s_dst(s_dst), .s_lat(s_lat), .s_rel_a(s_rel_a), .s_rel_b(s_rel_b),
      .out_delay(out_delay), .out_resched(out_resched), .wr_rel(wr_rel)
   );

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flush) |-> out_valid == $past(in_valid));
   // R8
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> out_valid == '0);
endmodule

// File: tb/tt_presched_bench.sv
`timescale 1ns/1ps
module tt_presched_bench;
   localparam int LANES = 4;
   localparam int REG_W = 5;
   localparam int LAT_W = 4;
   localparam int DLY_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [LANES-1:0] in_valid = '0;
   logic [LANES-1:0][REG_W-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic [LANES-1:0][LAT_W-1:0] in_lat = '0;
   logic [LANES-1:0] out_valid;
   logic [LANES-1:0][DLY_W-1:0] out_delay;
   logic [LANES-1:0] out_resched;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tt_presched u_tt_presched (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_dst(in_dst), .in_lat(in_lat),
      .out_valid(out_valid), .out_delay(out_delay), .out_resched(out_resched)
   );

   task automatic chk(string req, int got, int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic clear_in();
      in_valid = '0;
      in_src_a = '0;
      in_src_b = '0;
      in_dst = '0;
      in_lat = '0;
   endtask

   task automatic lane(int l, int a, int b, int d, int lat);
      in_valid[l] = 1'b1;
      in_src_a[l] = REG_W'(a);
      in_src_b[l] = REG_W'(b);
      in_dst[l]   = REG_W'(d);
      in_lat[l]   = LAT_W'(lat);
   endtask

   task automatic do_flush();
      clear_in();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 out_valid in reset", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      lane(0, 3, 4, 10, 5); lane(1, 7, 8, 11, 2);
      lane(2, 30, 31, 12, 9); lane(3, 1, 2, 13, 1);
      @(negedge clk);
      clear_in();
      chk("R1 valid", int'(out_valid), 15);
      for (int l = 0; l < LANES; l++) chk("R1 delay", int'(out_delay[l]), 0);
   endtask

   task automatic t_same_group();
      do_flush();
      lane(0, 1, 2, 5, 3);
      lane(1, 5, 3, 6, 2);
      lane(2, 6, 5, 7, 1);
      lane(3, 9, 10, 8, 1);
      @(negedge clk);
      chk("R4 lane0", int'(out_delay[0]), 0);
      chk("R4 lane1", int'(out_delay[1]), 3);
      chk("R3 later source wins", int'(out_delay[2]), 5);
      chk("R4 lane3", int'(out_delay[3]), 0);
      // next group, one cycle later
      clear_in();
      lane(0, 7, 0, 20, 1);
      lane(1, 0, 6, 21, 1);
      lane(2, 5, 0, 22, 1);
      lane(3, 8, 0, 23, 1);
      @(negedge clk);
      clear_in();
      chk("R5 lane0", int'(out_delay[0]), 5);
      chk("R5 lane1", int'(out_delay[1]), 4);
      chk("R5 lane2", int'(out_delay[2]), 2);
      chk("R5 lane3", int'(out_delay[3]), 0);
   endtask

   task automatic t_valid_timing();
      do_flush();
      @(negedge clk);
      lane(0, 0, 0, 1, 1); lane(2, 0, 0, 2, 1);
      in_valid = 4'b0101;
      #1;
      chk("R2 same cycle", int'(out_valid), 0);
      @(negedge clk);
      clear_in();
      chk("R2 next cycle", int'(out_valid), 5);
      @(negedge clk);
      chk("R2 idle", int'(out_valid), 0);
   endtask

   task automatic t_aging();
      do_flush();
      lane(0, 0, 0, 4, 10);
      @(negedge clk);
      clear_in();
      chk("R3 producer", int'(out_delay[0]), 0);
      repeat (3) @(negedge clk);
      lane(0, 4, 0, 17, 1);
      @(negedge clk);
      clear_in();
      chk("R3 four cycles later", int'(out_delay[0]), 6);
      repeat (300) @(negedge clk);
      lane(0, 4, 17, 18, 1);
      @(negedge clk);
      clear_in();
      chk("R9 after wrap", int'(out_delay[0]), 0);
   endtask

   task automatic t_waw();
      do_flush();
      lane(0, 0, 0, 9, 12);
      lane(1, 9, 0, 13, 1);
      lane(2, 0, 0, 9, 5);
      lane(3, 0, 9, 24, 1);
      @(negedge clk);
      chk("R6 lane1 sees lane0", int'(out_delay[1]), 12);
      chk("R6 lane3 sees lane2", int'(out_delay[3]), 5);
      clear_in();
      lane(0, 9, 0, 14, 1);
      @(negedge clk);
      clear_in();
      lane(0, 0, 9, 15, 1);
      chk("R6 bypass youngest", int'(out_delay[0]), 4);
      @(negedge clk);
      clear_in();
      chk("R6 table youngest", int'(out_delay[0]), 3);
   endtask

   task automatic t_cap();
      do_flush();
      lane(0, 0, 0, 1, 15);
      lane(1, 1, 0, 2, 15);
      lane(2, 2, 0, 3, 1);
      lane(3, 0, 3, 4, 1);
      @(negedge clk);
      clear_in();
      chk("R7 delay lane1", int'(out_delay[1]), 15);
      chk("R7 flag lane1", int'(out_resched[1]), 0);
      chk("R7 delay lane2", int'(out_delay[2]), 15);
      chk("R7 flags", int'(out_resched), 12);
   endtask

   task automatic t_invalid();
      do_flush();
      lane(0, 0, 0, 5, 9);
      lane(1, 5, 0, 6, 2);
      lane(2, 0, 0, 6, 9);
      lane(3, 6, 0, 25, 1);
      in_valid = 4'b1010;
      @(negedge clk);
      clear_in();
      chk("R10 valid mask", int'(out_valid), 10);
      chk("R10 lane1 ignores lane0", int'(out_delay[1]), 0);
      chk("R10 lane3 ignores lane2", int'(out_delay[3]), 2);
      lane(0, 5, 0, 16, 1);
      lane(1, 6, 0, 26, 1);
      @(negedge clk);
      clear_in();
      chk("R10 no write reg5", int'(out_delay[0]), 0);
      chk("R10 no write reg6", int'(out_delay[1]), 1);
   endtask

   task automatic t_flush();
      do_flush();
      lane(0, 0, 0, 11, 9);
      @(negedge clk);
      chk("R8 producer", int'(out_delay[0]), 0);
      lane(0, 11, 0, 27, 1); lane(1, 0, 0, 28, 1);
      lane(2, 0, 0, 29, 1); lane(3, 0, 0, 30, 1);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      clear_in();
      chk("R8 dropped", int'(out_valid), 0);
      lane(0, 11, 0, 12, 1);
      @(negedge clk);
      clear_in();
      chk("R8 cleared table", int'(out_delay[0]), 0);
      chk("R8 resumes", int'(out_valid), 1);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_same_group();
      t_valid_timing();
      t_aging();
      t_waw();
      t_cap();
      t_invalid();
      t_flush();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule